// File: doc/BRIEF.md
# FIFO Level and Threshold Interrupt Unit

This unit sits between a serial shifting engine and a host register interface. It holds one transmit and one receive FIFO that share a fixed byte budget. The number of words each FIFO can hold shrinks as the selected word length grows. The host writes transmit words and reads receive words. The shifter takes transmit words and delivers receive words. Both sides see the fill levels and a receive-empty bit.

Two level-sensitive threshold interrupts are produced, one per direction. Each one's condition is picked by a 2-bit mode code. The unit also keeps three sticky error flags: receive overflow, transmit underrun and frame error. Each flag has its own enable into a combined fault interrupt. The host clears the flags by writing ones.

Top module: `fifo_thresh_irq`

## Requirements
- R1: Each FIFO holds ceil(16 / bytes_per_word) words for the active word-length code `word_sel`. Code 0 selects 8-bit words and a depth of 16. Code 1 selects 16-bit words and a depth of 8. Codes 2 and 3 select 32-bit words and a depth of 4.
- R2: `tx_level` and `rx_level` are 5-bit word counts and read 0 after reset. Each accepted push adds one, and each accepted pop removes one. When a push and a pop are both accepted in the same cycle, the count does not change.
- R3: The read data of each FIFO is its oldest word, with every bit above the active word width forced to zero. The read data reads zero while the FIFO is empty.
- R4: A push is accepted only while the level is below the depth. A pop is accepted only while the level is above zero. A push or pop that is refused leaves the level and the stored data unchanged.
- R5: `rx_empty` is 1 exactly while the receive level is 0.
- R6: `rx_irq` is re-evaluated every cycle from `rx_mode`. Code 0 means the level is 0. Code 1 means the level is not 0. Code 2 means the level is at least half the depth. Code 3 means the level equals the depth.
- R7: `tx_irq` is re-evaluated every cycle from `tx_mode`. Code 0 means the level is 0 and `shifter_busy` is low. Code 1 means the level is 0. Code 2 means the free slots are at least half the depth. Code 3 means at least one slot is free.
- R8: A receive push refused because the FIFO is full sets `err_flags` bit 0 (receive overflow). The flag stays set until it is cleared.
- R9: A transmit pop refused because the FIFO is empty sets `err_flags` bit 1 (transmit underrun). The flag stays set until it is cleared.
- R10: A pulse on `frame_err` sets `err_flags` bit 2. The flag stays set until it is cleared.
- R11: While `clr_we` is high, every flag whose `clr_bits` bit is 1 clears on the next edge. A flag set event in the same cycle wins over the clear.
- R12: `fault_irq` is high while any flag is set whose `err_en` bit (same bit position) is also 1.
- R13: A change of the `word_sel` code empties both FIFOs on the next edge. In that cycle, pushes and pops are dropped and raise no overflow or underrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_sel | input | 2 | Word-length code |
| rx_mode | input | 2 | Receive interrupt condition code |
| tx_mode | input | 2 | Transmit interrupt condition code |
| err_en | input | 3 | Per-flag fault interrupt enables |
| tx_push | input | 1 | Host writes a transmit word |
| tx_wdata | input | 32 | Transmit word from host |
| tx_pop | input | 1 | Shifter takes a transmit word |
| tx_rdata | output | 32 | Oldest transmit word |
| shifter_busy | input | 1 | Shifter still holds a word |
| rx_push | input | 1 | Shifter delivers a receive word |
| rx_wdata | input | 32 | Receive word from shifter |
| rx_pop | input | 1 | Host reads a receive word |
| rx_rdata | output | 32 | Oldest receive word |
| frame_err | input | 1 | Frame error event |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 3 | Write-one-to-clear mask |
| tx_level | output | 5 | Transmit fill level |
| rx_level | output | 5 | Receive fill level |
| rx_empty | output | 1 | Receive FIFO empty |
| err_flags | output | 3 | Sticky error flags |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit threshold interrupt |
| fault_irq | output | 1 | Enabled error interrupt |

## Verification
The in-line assertions check these rules on every cycle:
- a level never goes above the active depth;
- a refused push or pop leaves the level unchanged;
- a word-length change empties both FIFOs;
- a flag stays set unless it is cleared, and its set event wins over a same-cycle clear;
- a full receive push raises the overflow flag;
- with no enables set, the fault interrupt stays low.

Data ordering, masking of the upper bits and the exact threshold edge for each mode code and depth are shown only by the bench's reference model. It checks them across fill and drain sweeps at every word length, including mid-fill word-length changes.

// File: rtl/fifo_stat_pkg.sv
package fifo_stat_pkg;

   typedef enum logic [1:0] {
      WL_BYTE  = 2'd0,
      WL_HALF  = 2'd1,
      WL_WORD  = 2'd2,
      WL_WORDB = 2'd3
   } wlen_e;

   localparam int unsigned N_ERR   = 3;
   localparam int unsigned ERR_OVF = 0;
   localparam int unsigned ERR_UDR = 1;
   localparam int unsigned ERR_FRM = 2;

   function automatic int unsigned bytes_of(input logic [1:0] code);
      case (code)
         WL_BYTE: return 1;
         WL_HALF: return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MAX_DEPTH = 16,
   parameter int unsigned LVL_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [LVL_W-1:0]  depth,
   input  logic [DATA_W-1:0] mask,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [LVL_W-1:0]  level,
   output logic              push_drop,
   output logic              pop_drop
);
   localparam int unsigned PTR_W = $clog2(MAX_DEPTH);

   if (LVL_W != PTR_W + 1) begin : g_bad_lvl
      $error("fifo_store: LVL_W must be clog2(MAX_DEPTH)+1");
   end

   logic [DATA_W-1:0] mem [MAX_DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [LVL_W-1:0]  count;
   logic              push_ok, pop_ok;

   assign push_ok   = push && (count < depth);
   assign pop_ok    = pop && (count != '0);
   assign push_drop = push && !push_ok;
   assign pop_drop  = pop && !pop_ok;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                             input logic [LVL_W-1:0] d);
      if (LVL_W'(p) == d - LVL_W'(1)) return '0;
      return p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= bump(wr_ptr, depth);
         if (pop_ok)  rd_ptr <= bump(rd_ptr, depth);
         count <= count + LVL_W'(push_ok) - LVL_W'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= wdata & mask;
   end

   assign rdata = (count == '0) ? '0 : (mem[rd_ptr] & mask);
   assign level = count;

   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= depth);

   a_r4_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && push && !pop && level == depth) |=> $stable(level));

   a_r4_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && pop && !push && level == '0) |=> (level == '0));

   a_r13_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));

endmodule

// File: rtl/thresh_eval.sv
module thresh_eval #(
   parameter int unsigned LVL_W = 5,
   parameter bit          IS_TX = 1'b0
) (
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] depth,
   input  logic [1:0]       mode,
   input  logic             shifter_busy,
   output logic             irq
);
   logic [LVL_W-1:0] half;
   assign half = depth >> 1;

   if (IS_TX) begin : g_tx
      logic [LVL_W-1:0] room;
      assign room = depth - level;
      always_comb begin
         case (mode)
            2'd0:    irq = (level == '0) && !shifter_busy;
            2'd1:    irq = (level == '0);
            2'd2:    irq = (room >= half);
            default: irq = (room != '0);
         endcase
      end
   end else begin : g_rx
      always_comb begin
         case (mode)
            2'd0:    irq = (level == '0);
            2'd1:    irq = (level != '0);
            2'd2:    irq = (level >= half);
            default: irq = (level == depth);
         endcase
      end
   end

endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic         clr_we,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] enables,
   output logic [N-1:0] flags,
   output logic         fault
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     flags[i] <= 1'b0;
         else if (set_evt[i])            flags[i] <= 1'b1;
         else if (clr_we && clr_bits[i]) flags[i] <= 1'b0;
      end

      a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !(clr_we && clr_bits[i])) |=> flags[i]);

      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[i] |=> flags[i]);
   end

   assign fault = |(flags & enables);

   a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (enables == '0) |-> !fault);

endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
   import fifo_stat_pkg::*;
#(
   parameter int unsigned STORE_BYTES = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LVL_W       = $clog2(STORE_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        word_sel,
   input  logic [1:0]        rx_mode,
   input  logic [1:0]        tx_mode,
   input  logic [2:0]        err_en,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_rdata,
   input  logic              shifter_busy,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_wdata,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   input  logic              frame_err,
   input  logic              clr_we,
   input  logic [2:0]        clr_bits,
   output logic [LVL_W-1:0]  tx_level,
   output logic [LVL_W-1:0]  rx_level,
   output logic              rx_empty,
   output logic [2:0]        err_flags,
   output logic              rx_irq,
   output logic              tx_irq,
   output logic              fault_irq
);
   localparam int unsigned DEPTH_B = STORE_BYTES;
   localparam int unsigned DEPTH_H = (STORE_BYTES + 1) / 2;
   localparam int unsigned DEPTH_W = (STORE_BYTES + 3) / 4;

   if (DATA_W != 32) begin : g_bad_data
      $error("fifo_thresh_irq: DATA_W must be 32");
   end
   if (STORE_BYTES < 4 || (STORE_BYTES & (STORE_BYTES - 1)) != 0) begin : g_bad_store
      $error("fifo_thresh_irq: STORE_BYTES must be a power of two, at least 4");
   end
   if (LVL_W != $clog2(STORE_BYTES) + 1) begin : g_bad_lvl
      $error("fifo_thresh_irq: LVL_W must be clog2(STORE_BYTES)+1");
   end

   logic [1:0]        cfg_q;
   logic              flush;
   logic [LVL_W-1:0]  depth;
   logic [DATA_W-1:0] mask;
   logic              tx_push_drop, tx_pop_drop, rx_push_drop, rx_pop_drop;
   logic [N_ERR-1:0]  err_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= WL_BYTE;
      else        cfg_q <= word_sel;
   end

   assign flush = (word_sel != cfg_q);

   always_comb begin
      case (bytes_of(cfg_q))
         1:       begin depth = LVL_W'(DEPTH_B); mask = DATA_W'(32'h0000_00FF); end
         2:       begin depth = LVL_W'(DEPTH_H); mask = DATA_W'(32'h0000_FFFF); end
         default: begin depth = LVL_W'(DEPTH_W); mask = '1; end
      endcase
   end

   fifo_store #(.DATA_W(DATA_W), .MAX_DEPTH(STORE_BYTES), .LVL_W(LVL_W)) u_tx_fifo (
      .clk, .rst_n, .flush, .depth, .mask,
      .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
      .level(tx_level), .push_drop(tx_push_drop), .pop_drop(tx_pop_drop)
   );

   fifo_store #(.DATA_W(DATA_W), .MAX_DEPTH(STORE_BYTES), .LVL_W(LVL_W)) u_rx_fifo (
      .clk, .rst_n, .flush, .depth, .mask,
      .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
      .level(rx_level), .push_drop(rx_push_drop), .pop_drop(rx_pop_drop)
   );

   thresh_eval #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx_thr (
      .level(rx_level), .depth, .mode(rx_mode), .shifter_busy(1'b0), .irq(rx_irq)
   );

   thresh_eval #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx_thr (
      .level(tx_level), .depth, .mode(tx_mode), .shifter_busy, .irq(tx_irq)
   );

   always_comb begin
      err_set          = '0;
      err_set[ERR_OVF] = rx_push_drop && !flush;
      err_set[ERR_UDR] = tx_pop_drop && !flush;
      err_set[ERR_FRM] = frame_err;
   end

   err_flag_bank #(.N(N_ERR)) u_errs (
      .clk, .rst_n, .set_evt(err_set), .clr_we, .clr_bits,
      .enables(err_en), .flags(err_flags), .fault(fault_irq)
   );

   assign rx_empty = (rx_level == '0);

   a_r8_overflow_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && !rx_pop && !flush && rx_level == depth) |=> err_flags[ERR_OVF]);

   a_r9_underrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && !flush && tx_level == '0) |=> err_flags[ERR_UDR]);

   a_r1_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LVL_W'(STORE_BYTES)) && (rx_level <= LVL_W'(STORE_BYTES)));

   // r4_unused drop outputs are consumed only through the flag bank
   logic unused_drops;
   assign unused_drops = tx_push_drop ^ rx_pop_drop;

endmodule

// File: tb/fifo_thresh_irq_tb_top.sv
module fifo_thresh_irq_tb_top;
   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  word_sel = 0, rx_mode = 0, tx_mode = 0;
   logic [2:0]  err_en = 0, clr_bits = 0;
   logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
   logic [31:0] tx_wdata = 0, rx_wdata = 0;
   logic        shifter_busy = 0, frame_err = 0, clr_we = 0;
   logic [31:0] tx_rdata, rx_rdata;
   logic [4:0]  tx_level, rx_level;
   logic        rx_empty, rx_irq, tx_irq, fault_irq;
   logic [2:0]  err_flags;

   int checks = 0;
   int errors = 0;

   logic [31:0] txq[$];
   logic [31:0] rxq[$];
   logic [1:0]  cfg_m = 0;
   logic [2:0]  fl_m = 0;

   always #(CLK_P/2) clk = ~clk;

   fifo_thresh_irq dut_i (
      .clk, .rst_n, .word_sel, .rx_mode, .tx_mode, .err_en,
      .tx_push, .tx_wdata, .tx_pop, .tx_rdata, .shifter_busy,
      .rx_push, .rx_wdata, .rx_pop, .rx_rdata, .frame_err,
      .clr_we, .clr_bits, .tx_level, .rx_level, .rx_empty,
      .err_flags, .rx_irq, .tx_irq, .fault_irq
   );

   // R1: depth per word-length code
   function automatic int depth_m(logic [1:0] w);
      return (w == 0) ? 16 : (w == 1) ? 8 : 4;
   endfunction

   function automatic logic [31:0] mask_m(logic [1:0] w);
      return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic model_update();
      logic [2:0] set_v;
      int d, ts, rs;
      bit tpu, tpo, rpu, rpo;
      set_v = {frame_err, 2'b00};
      if (word_sel != cfg_m) begin
         txq.delete();
         rxq.delete();
         cfg_m = word_sel;
      end else begin
         d  = depth_m(cfg_m);
         ts = txq.size();
         rs = rxq.size();
         tpu = tx_push && ts < d;
         tpo = tx_pop && ts > 0;
         rpu = rx_push && rs < d;
         rpo = rx_pop && rs > 0;
         set_v[1] = tx_pop && ts == 0;
         set_v[0] = rx_push && rs == d;
         if (tpo) void'(txq.pop_front());
         if (tpu) txq.push_back(tx_wdata & mask_m(cfg_m));
         if (rpo) void'(rxq.pop_front());
         if (rpu) rxq.push_back(rx_wdata & mask_m(cfg_m));
      end
      fl_m = (fl_m & ~(clr_we ? clr_bits : 3'b000)) | set_v;
   endtask

   task automatic compare();
      int d, tn, rn;
      bit erx, etx;
      logic [31:0] etd, erd;
      d  = depth_m(cfg_m);
      tn = txq.size();
      rn = rxq.size();
      etd = (tn == 0) ? 32'h0 : txq[0];
      erd = (rn == 0) ? 32'h0 : rxq[0];
      case (rx_mode)
         0: erx = (rn == 0);
         1: erx = (rn != 0);
         2: erx = (rn >= d/2);
         default: erx = (rn == d);
      endcase
      case (tx_mode)
         0: etx = (tn == 0) && !shifter_busy;
         1: etx = (tn == 0);
         2: etx = ((d - tn) >= d/2);
         default: etx = (tn < d);
      endcase
      chk(int'(tx_level) == tn, "R1 R2 R4 R13 tx_level", tx_level, tn);
      chk(int'(rx_level) == rn, "R1 R2 R4 R13 rx_level", rx_level, rn);
      chk(tx_rdata == etd, "R3 tx_rdata", tx_rdata, etd);
      chk(rx_rdata == erd, "R3 rx_rdata", rx_rdata, erd);
      chk(rx_empty == (rn == 0), "R5 rx_empty", rx_empty, rn == 0);
      chk(rx_irq == erx, "R6 rx_irq", rx_irq, erx);
      chk(tx_irq == etx, "R7 tx_irq", tx_irq, etx);
      chk(err_flags[0] == fl_m[0], "R8 R11 overflow flag", err_flags[0], fl_m[0]);
      chk(err_flags[1] == fl_m[1], "R9 R11 underrun flag", err_flags[1], fl_m[1]);
      chk(err_flags[2] == fl_m[2], "R10 R11 frame flag", err_flags[2], fl_m[2]);
      chk(fault_irq == |(fl_m & err_en), "R12 fault_irq", fault_irq, |(fl_m & err_en));
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   task automatic idle_inputs();
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
      frame_err = 0; clr_we = 0; clr_bits = 0;
   endtask

   // pushes with probability pu/100 and pops with po/100, random modes
   task automatic phase(input int n, input int pu, input int po);
      for (int i = 0; i < n; i++) begin
         tx_push  = ($urandom % 100) < pu;
         rx_push  = ($urandom % 100) < pu;
         tx_pop   = ($urandom % 100) < po;
         rx_pop   = ($urandom % 100) < po;
         tx_wdata = $urandom;
         rx_wdata = $urandom;
         rx_mode  = 2'($urandom);
         tx_mode  = 2'($urandom);
         shifter_busy = 1'($urandom);
         err_en   = 3'($urandom);
         frame_err = ($urandom % 40) == 0;
         clr_we   = ($urandom % 6) == 0;
         clr_bits = 3'($urandom);
         step();
      end
      idle_inputs();
   endtask

   initial begin
      #(CLK_P * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(); // R2 reset state
      rst_n = 1'b1;
      step();

      // R6/R7 sweep every mode at each fill level, 8-bit words
      for (int lv = 0; lv < 17; lv++) begin
         for (int m = 0; m < 4; m++) begin
            rx_mode = 2'(m); tx_mode = 2'(m); shifter_busy = 1'(lv % 2);
            step();
         end
         tx_push = 1; rx_push = 1; tx_wdata = 32'hA5A5_0000 + lv; rx_wdata = 32'h1234_5600 + lv;
         step();
         idle_inputs();
      end
      // R8: overflow on full receive, R4: level held
      rx_push = 1; step(); step(); idle_inputs();
      // R11: clear while a new overflow arrives, then plain clear
      rx_push = 1; clr_we = 1; clr_bits = 3'b111; step(); idle_inputs();
      clr_we = 1; clr_bits = 3'b001; err_en = 3'b001; step(); idle_inputs();
      // R3: drain in order
      for (int i = 0; i < 18; i++) begin tx_pop = 1; rx_pop = 1; step(); end
      idle_inputs(); // R9 underrun raised by last pops
      err_en = 3'b010; step();
      frame_err = 1; err_en = 3'b100; step(); idle_inputs(); step(); // R10

      // R1 per word length, R13 mid-fill change
      for (int w = 0; w < 4; w++) begin
         word_sel = 2'(w);
         step();
         phase(30, 90, 10);
         phase(30, 10, 90);
         phase(10, 90, 10);
      end
      word_sel = 1; phase(1, 100, 100); // R13: change cycle drops traffic
      phase(20, 80, 20);
      word_sel = 2; step(); // R13 flush with data held
      // long mixed run
      for (int b = 0; b < 60; b++) begin
         if ((b % 7) == 0) word_sel = 2'($urandom);
         phase(40, 30 + ($urandom % 60), 30 + ($urandom % 60));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule